// File: doc/BRIEF.md
# BCD Calendar Timekeeping Counter

This block keeps a running time of day and calendar date in packed BCD. Each cycle in which the one-second strobe `tick_i` is high advances the count by one second. Seconds carry into minutes, minutes into hours, and hours into the date. The date carries into the month and the month into a two-digit year. A day-of-week counter steps on every date change. Hours run in either a 24-hour format or a 12-hour format with a PM flag. Month lengths follow the calendar, and February gains a 29th day in leap years.

A host reaches seven byte-wide registers through a parallel port. A write replaces the selected register with the written byte in the next cycle. A read is a combinational mux on `addr_i`. Bit 7 of the seconds register is a run/halt control: while it is 1, strobes are ignored. Bit 7 of the hours register selects the hour format.

Top module: `bcd_rtc`

## Requirements
- R1: After reset the registers read seconds 0x00, minutes 0x00, hours 0x00 (24-hour mode), day of week 0x01, date 0x01, month 0x01 and year 0x00.
- R2: Register map: address 0 is seconds, 1 minutes, 2 hours, 3 day of week, 4 date, 5 month and 6 year. On a strobe the seconds count up in BCD, and 0x59 wraps to 0x00 and advances the minutes. Minutes behave the same way, and a minute wrap advances the hours.
- R3: Seconds bit 7 is the halt flag. While it is 1, a strobe changes no register. After bit 7 is written back to 0, strobes advance the count again, and bit 7 stays 0.
- R4: With hours bit 7 at 0 (24-hour mode), hours run 0x00 to 0x23, with bit 5 as the tens digit for 20 to 23. A wrap from 0x23 to 0x00 advances the date.
- R5: With hours bit 7 at 1 (12-hour mode), bits 4..0 hold the hour 01 to 12 and bit 5 is the PM flag (1 = PM). 11 steps to 12 and toggles the flag, and 12 steps to 01 with the flag kept. The date advances only on the step from 11 PM to 12 AM. Bit 7 never changes except by a write.
- R6: The date wraps to 0x01 after 0x30 in months 0x04, 0x06, 0x09 and 0x11, and after 0x31 in the other months except February, and the month then advances. Month 0x12 wraps to 0x01 and advances the year. Year 0x99 wraps to 0x00.
- R7: February ends on 0x29 when the two-digit year is divisible by four, including 00, and on 0x28 otherwise.
- R8: The day of week steps by one on each date advance, and 0x07 wraps to 0x01.
- R9: When `wr_en_i` is high, the register at `addr_i` takes `wdata_i` at the next edge. A strobe in the same cycle is dropped and no other register changes.
- R10: In a cycle with neither a strobe nor a write, no register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | One-second strobe, high for one cycle |
| wr_en_i | input | 1 | Host write enable |
| addr_i | input | 3 | Register address for reads and writes |
| wdata_i | input | 8 | Host write data |
| rdata_o | output | 8 | Read data of the addressed register (combinational) |

## Verification
The range assertions assume the host only ever writes legal BCD values: seconds up to 0x59 and a 24-hour hour up to 0x23. The counter never steps out of range on its own, but it holds whatever the host stores. Every write the bench makes is a valid time or date, so these assertions stay meaningful. The stability assertions assume that strobes and writes are single-cycle requests sampled at the clock edge. The bench drives both for exactly one cycle between falling edges.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
    localparam int BYTE_W = 8;
    localparam int ADDR_W = 3;
    localparam int NUM_REGS = 7;

    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic [ADDR_W-1:0] {
        A_SEC  = 3'd0,
        A_MIN  = 3'd1,
        A_HOUR = 3'd2,
        A_DOW  = 3'd3,
        A_DATE = 3'd4,
        A_MON  = 3'd5,
        A_YEAR = 3'd6
    } reg_addr_e;

    typedef struct packed {
        byte_t sec;
        byte_t min;
        byte_t hour;
        byte_t dow;
        byte_t date;
        byte_t mon;
        byte_t year;
    } rtc_state_t;

    // Packed-BCD increment of a two-digit value; no range wrap applied here.
    function automatic byte_t bcd_inc(input byte_t v);
        byte_t r;
        if (v[3:0] == 4'd9) r = {v[7:4] + 4'd1, 4'd0};
        else                r = {v[7:4], v[3:0] + 4'd1};
        return r;
    endfunction
endpackage

// File: rtl/rtc_hour_step.sv
module rtc_hour_step
    import rtc_pkg::*;
(
    input  byte_t hour_i,
    output byte_t hour_o,
    output logic  day_carry_o
);
    byte_t inc;

    always_comb begin
        inc         = bcd_inc(hour_i);
        hour_o      = inc;
        day_carry_o = 1'b0;
        if (hour_i[7]) begin
            // 12-hour: bit 5 is the PM flag, bits 4..0 the hour 01..12
            hour_o[7] = 1'b1;
            hour_o[6] = 1'b0;
            hour_o[5] = hour_i[5];
            if (hour_i[4:0] == 5'h11) begin
                hour_o[5]   = ~hour_i[5];
                hour_o[4:0] = 5'h12;
                day_carry_o = hour_i[5];
            end else if (hour_i[4:0] == 5'h12) begin
                hour_o[4:0] = 5'h01;
            end
        end else begin
            // 24-hour: bits 5..0 hold 00..23
            hour_o[7] = 1'b0;
            hour_o[6] = 1'b0;
            if (hour_i[5:0] == 6'h23) begin
                hour_o      = '0;
                day_carry_o = 1'b1;
            end
        end
    end
endmodule

// File: rtl/rtc_month_len.sv
module rtc_month_len
    import rtc_pkg::*;
(
    input  byte_t      mon_i,
    input  logic       year_tens_lsb_i,
    input  logic [1:0] year_ones_lsbs_i,
    output byte_t      last_date_o
);
    logic [1:0] mod4;
    logic       leap;

    // (10*tens + ones) mod 4 == (2*tens + ones) mod 4
    always_comb begin
        mod4 = {year_tens_lsb_i, 1'b0} + year_ones_lsbs_i;
        leap = (mod4 == 2'd0);
        unique case (mon_i)
            8'h02:                      last_date_o = leap ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: last_date_o = 8'h30;
            default:                    last_date_o = 8'h31;
        endcase
    end
endmodule

// File: rtl/bcd_rtc.sv
module bcd_rtc
    import rtc_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              tick_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [BYTE_W-1:0] wdata_i,
    output logic [BYTE_W-1:0] rdata_o
);
    localparam rtc_state_t RESET_STATE = '{
        sec: 8'h00, min: 8'h00, hour: 8'h00, dow: 8'h01,
        date: 8'h01, mon: 8'h01, year: 8'h00
    };

    rtc_state_t st_d, st_q;
    byte_t      hour_next;
    logic       day_carry;
    byte_t      last_date;

    rtc_hour_step u_hour (
        .hour_i      (st_q.hour),
        .hour_o      (hour_next),
        .day_carry_o (day_carry)
    );

    rtc_month_len u_mlen (
        .mon_i            (st_q.mon),
        .year_tens_lsb_i  (st_q.year[4]),
        .year_ones_lsbs_i (st_q.year[1:0]),
        .last_date_o      (last_date)
    );

    always_comb begin
        st_d = st_q;
        if (wr_en_i) begin
            unique case (reg_addr_e'(addr_i))
                A_SEC:   st_d.sec  = wdata_i;
                A_MIN:   st_d.min  = wdata_i;
                A_HOUR:  st_d.hour = wdata_i;
                A_DOW:   st_d.dow  = wdata_i;
                A_DATE:  st_d.date = wdata_i;
                A_MON:   st_d.mon  = wdata_i;
                A_YEAR:  st_d.year = wdata_i;
                default: st_d = st_q;
            endcase
        end else if (tick_i && !st_q.sec[7]) begin
            if (st_q.sec == 8'h59) begin
                st_d.sec = 8'h00;
                if (st_q.min == 8'h59) begin
                    st_d.min  = 8'h00;
                    st_d.hour = hour_next;
                    if (day_carry) begin
                        st_d.dow = (st_q.dow == 8'h07) ? 8'h01 : bcd_inc(st_q.dow);
                        if (st_q.date == last_date) begin
                            st_d.date = 8'h01;
                            if (st_q.mon == 8'h12) begin
                                st_d.mon  = 8'h01;
                                st_d.year = (st_q.year == 8'h99) ? 8'h00 : bcd_inc(st_q.year);
                            end else begin
                                st_d.mon = bcd_inc(st_q.mon);
                            end
                        end else begin
                            st_d.date = bcd_inc(st_q.date);
                        end
                    end
                end else begin
                    st_d.min = bcd_inc(st_q.min);
                end
            end else begin
                st_d.sec = bcd_inc(st_q.sec);
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= RESET_STATE;
        else         st_q <= st_d;
    end

    always_comb begin
        unique case (reg_addr_e'(addr_i))
            A_SEC:   rdata_o = st_q.sec;
            A_MIN:   rdata_o = st_q.min;
            A_HOUR:  rdata_o = st_q.hour;
            A_DOW:   rdata_o = st_q.dow;
            A_DATE:  rdata_o = st_q.date;
            A_MON:   rdata_o = st_q.mon;
            A_YEAR:  rdata_o = st_q.year;
            default: rdata_o = '0;
        endcase
    end
endmodule

// File: rtl/rtc_checks.sv
module rtc_checks
    import rtc_pkg::*;
(
    input logic              clk_i,
    input logic              rst_ni,
    input logic              tick_i,
    input logic              wr_en_i,
    input logic [ADDR_W-1:0] addr_i,
    input logic [BYTE_W-1:0] wdata_i,
    input rtc_state_t        st_q
);
    assert_sec_load_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && addr_i == 3'd0) |=> (st_q.sec == $past(wdata_i)));

    assert_hour_load_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && addr_i == 3'd2) |=> (st_q.hour == $past(wdata_i)));

    assert_halt_freeze_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!wr_en_i && st_q.sec[7]) |=> $stable(st_q));

    assert_idle_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!wr_en_i && !tick_i) |=> $stable(st_q));

    assert_sec_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.sec[3:0] <= 4'd9) && (st_q.sec[6:4] <= 3'd5));

    assert_hour24_range_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !st_q.hour[7] |-> (st_q.hour[5:0] <= 6'h23));

    assert_mode_kept_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !wr_en_i |=> (st_q.hour[7] == $past(st_q.hour[7])));

    assert_dow_follows_date_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!$past(wr_en_i) && (st_q.date != $past(st_q.date))) |-> (st_q.dow != $past(st_q.dow)));
endmodule

bind bcd_rtc rtc_checks u_rtc_checks (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick_i),
    .wr_en_i (wr_en_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .st_q    (st_q)
);

// File: tb/tb_bcd_rtc.sv
module tb_bcd_rtc;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 21;

    logic       clk_i = 1'b0;
    logic       rst_ni = 1'b0;
    logic       tick_i = 1'b0;
    logic       wr_en_i = 1'b0;
    logic [2:0] addr_i = 3'd0;
    logic [7:0] wdata_i = 8'h00;
    logic [7:0] rdata_o;

    int n_checks = 0;
    int n_errors = 0;

    bcd_rtc dut (.*);

    always #(CLK_PERIOD/2) clk_i = ~clk_i;

    // Fields: {sec, min, hour, dow, date, month, year}; address = field index.
    localparam logic [55:0] VIN [NV] = '{
        56'h00_00_00_01_01_01_00, 56'h09_00_00_01_01_01_00, 56'h59_09_00_01_01_01_00,
        56'h59_59_09_01_01_01_00, 56'h59_59_19_02_05_03_21, 56'h59_59_23_03_15_05_24,
        56'h59_59_91_01_01_01_00, 56'h59_59_B2_01_01_01_00, 56'h59_59_B1_05_10_06_30,
        56'h59_59_92_01_01_01_00, 56'h59_59_23_07_30_04_15, 56'h59_59_23_02_31_01_15,
        56'h59_59_23_04_31_12_99, 56'h59_59_23_01_28_02_24, 56'h59_59_23_02_29_02_24,
        56'h59_59_23_03_28_02_23, 56'h59_59_23_06_28_02_00, 56'h59_59_23_01_30_11_09,
        56'h59_59_23_01_29_04_09, 56'h59_59_23_01_28_02_12, 56'h59_59_23_01_28_02_10
    };
    localparam logic [55:0] VEXP [NV] = '{
        56'h01_00_00_01_01_01_00, 56'h10_00_00_01_01_01_00, 56'h00_10_00_01_01_01_00,
        56'h00_00_10_01_01_01_00, 56'h00_00_20_02_05_03_21, 56'h00_00_00_04_16_05_24,
        56'h00_00_B2_01_01_01_00, 56'h00_00_A1_01_01_01_00, 56'h00_00_92_06_11_06_30,
        56'h00_00_81_01_01_01_00, 56'h00_00_00_01_01_05_15, 56'h00_00_00_03_01_02_15,
        56'h00_00_00_05_01_01_00, 56'h00_00_00_02_29_02_24, 56'h00_00_00_03_01_03_24,
        56'h00_00_00_04_01_03_23, 56'h00_00_00_07_29_02_00, 56'h00_00_00_02_01_12_09,
        56'h00_00_00_02_30_04_09, 56'h00_00_00_02_29_02_12, 56'h00_00_00_02_01_03_10
    };
    // Requirement exercised by each vector
    localparam logic [15:0] VTAG [NV] = '{
        "R2", "R2", "R2", "R2", "R4", "R4", "R5", "R5", "R5", "R5", "R8",
        "R6", "R6", "R7", "R7", "R7", "R7", "R6", "R6", "R7", "R7"
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic host_write(input logic [2:0] a, input logic [7:0] d, input logic with_tick);
        @(negedge clk_i);
        wr_en_i = 1'b1; addr_i = a; wdata_i = d; tick_i = with_tick;
        @(negedge clk_i);
        wr_en_i = 1'b0; tick_i = 1'b0;
    endtask

    task automatic pulse_tick();
        @(negedge clk_i);
        tick_i = 1'b1;
        @(negedge clk_i);
        tick_i = 1'b0;
    endtask

    task automatic read_reg(input logic [2:0] a, output logic [7:0] d);
        addr_i = a;
        #1;
        d = rdata_o;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_errors++;
        $display("FAIL watchdog expired (all R)");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        logic [7:0] rd;
        repeat (3) @(negedge clk_i);
        rst_ni = 1'b1;
        @(negedge clk_i);

        // R1 reset state
        for (int a = 0; a < 7; a++) begin
            read_reg(a[2:0], rd);
            check("R1", rd, VEXP[0][55-8*a -: 8] & ((a == 0) ? 8'h00 : 8'hFF));
        end

        // Table walk: load all registers, one strobe, read back all
        for (int v = 0; v < NV; v++) begin
            for (int a = 0; a < 7; a++) host_write(a[2:0], VIN[v][55-8*a -: 8], 1'b0);
            pulse_tick();
            for (int a = 0; a < 7; a++) begin
                read_reg(a[2:0], rd);
                check($sformatf("%s vec%0d reg%0d", VTAG[v], v, a), rd, VEXP[v][55-8*a -: 8]);
            end
        end

        // R3: halt holds the count, clearing resumes
        host_write(3'd1, 8'h42, 1'b0);
        host_write(3'd0, 8'h85, 1'b0);
        pulse_tick();
        pulse_tick();
        read_reg(3'd0, rd); check("R3 halted sec", rd, 8'h85);
        read_reg(3'd1, rd); check("R3 halted min", rd, 8'h42);
        host_write(3'd0, 8'h05, 1'b0);
        pulse_tick();
        read_reg(3'd0, rd); check("R3 resumed sec", rd, 8'h06);

        // R10: idle cycles change nothing
        repeat (5) @(negedge clk_i);
        read_reg(3'd0, rd); check("R10 idle sec", rd, 8'h06);

        // R9: write wins over a coincident strobe
        host_write(3'd1, 8'h30, 1'b1);
        read_reg(3'd1, rd); check("R9 written min", rd, 8'h30);
        read_reg(3'd0, rd); check("R9 sec untouched", rd, 8'h06);

        // R5: format bit survives a full 12-hour wrap with minutes running
        host_write(3'd2, 8'h92, 1'b0);
        host_write(3'd1, 8'h59, 1'b0);
        host_write(3'd0, 8'h58, 1'b0);
        pulse_tick();
        pulse_tick();
        read_reg(3'd2, rd); check("R5 12AM to 1AM", rd, 8'h81);
        read_reg(3'd0, rd); check("R2 sec wrap", rd, 8'h00);

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule